// File: doc/BRIEF.md
# Vertical-Sync-Clocked Display ID Transmitter

This block sends display identification bytes one bit at a time on a serial data line. The host clocks each bit with rising edges on the vertical-sync input, as in host-driven DDC1 operation. Each character takes nine bit slots: eight data bits, most significant bit first, and then a ninth slot that is always driven high. A transmit hold register supplies each character. The block reloads that register while the ninth slot is on the line. The reload comes from one of two places. In hardware mode it is read from a byte-wide buffer at a post-incrementing pointer. In software mode the CPU writes it after an interrupt.

The block also watches the DDC2 clock line. On the first falling edge seen on that line, it switches permanently to DDC2 mode. It then raises an interrupt, releases the data line, and stops responding to vertical-sync activity. Only a reset brings it back to DDC1 mode. Slave operation on the two-wire bus in DDC2 mode is handled elsewhere.

A CPU register port with four byte registers gives access to control, status, the pointer and the hold register.

Top module: `edid_ddc1_tx`

## Requirements
- R1: After reset, every register reads 0. This includes the mode bit, which reads 0 for DDC1. The data line reads 1 and the interrupt output reads 0. The register addresses are:
  - address 0: control. Bit 0 is enable, bit 1 selects the 256-byte size, bit 2 selects software refill.
  - address 1: status. Bit 0 is the refill flag and bit 1 is the switch flag. Both are cleared by writing 1. Bit 2 is the mode bit and is read-only.
  - address 2: pointer.
  - address 3: hold register.
- R2: Each character occupies nine bit slots, one slot per synchronized vertical-sync rising edge. The first edge starts slot 1, which drives the hold register's bit 7. Slots 2 to 8 drive bits 6 down to 0. Slot 9 drives 1.
- R3: With software refill off, the start of slot 9 loads the hold register from the buffer at the pointer. The pointer then advances by one. The buffer address output always equals the pointer.
- R4: The pointer wraps to 0 after 127 when the size bit is 0. When the size bit is 1, it goes from 127 to 128 and wraps to 0 after 255.
- R5: With software refill on, the start of slot 9 sets the refill flag, and the interrupt output goes high. The pointer and the hold register are left unchanged. The flag stays set until the CPU writes 1 to status bit 0.
- R6: In software refill mode, if the CPU does not write the hold register before the next character starts, the previous byte is sent again.
- R7: While enable is 0, vertical-sync edges have no effect. No bit is sent, the pointer does not move, and the slot position is kept.
- R8: A falling edge on the DDC2 clock while in DDC1 mode does three things. It sets the mode bit, sets the switch flag, and raises the interrupt output. The flag is cleared by writing 1 to status bit 1.
- R9: In DDC2 mode the data line is held high and vertical-sync edges are ignored. The mode stays DDC2 until reset, and further DDC2 clock falls do not set the switch flag again.
- R10: A vertical-sync edge takes effect on the data line at the third clock edge after the input changes. This delay comes from two synchronizer flops and one output register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| vsync_clk_i | input | 1 | Vertical-sync bit clock, asynchronous |
| ddc2_scl_i | input | 1 | DDC2 clock line, asynchronous, idles high |
| cpu_wr_i | input | 1 | Register write strobe |
| cpu_addr_i | input | 2 | Register address |
| cpu_wdata_i | input | 8 | Register write data |
| cpu_rdata_o | output | 8 | Register read data, combinational from the address |
| buf_addr_o | output | 8 | Buffer read address |
| buf_data_i | input | 8 | Buffer read data for `buf_addr_o`, same cycle |
| sda_o | output | 1 | Serial data out, 1 means high or released |
| irq_o | output | 1 | Interrupt request |

## Verification
A vertical-sync edge driven at a falling clock edge reaches the data line at the third rising edge after it. The latency check samples the line after the second rising edge, when it must still be unchanged, and again after the third, when it must have changed.

Every other bit is sampled four clock cycles after the vertical-sync edge. That is well after the third edge, and before the next edge is driven. The refill, pointer and flag updates happen on the same rising edge as the start of slot 9, so they are read back once the ninth pulse ends. A DDC2 clock fall is given four cycles to settle before the status register is read.

// File: rtl/edid_ddc1_pkg.sv
package edid_ddc1_pkg;

    typedef enum logic [1:0] {
        RA_CTRL = 2'd0,
        RA_STAT = 2'd1,
        RA_PTR  = 2'd2,
        RA_HOLD = 2'd3
    } reg_sel_e;

    typedef enum logic {
        MODE_DDC1 = 1'b0,
        MODE_DDC2 = 1'b1
    } ddc_mode_e;

    // control register fields, bit 0 upward: enable, size_large, sw_refill
    typedef struct packed {
        logic sw_refill;
        logic size_large;
        logic enable;
    } ctrl_t;

    // status register fields, bit 0 upward: refill flag, switch flag, mode
    typedef struct packed {
        logic mode;
        logic switch_flag;
        logic refill_flag;
    } stat_t;

    localparam int CTRL_W = $bits(ctrl_t);
    localparam int STAT_W = $bits(stat_t);

endpackage

// File: rtl/edge_sync.sv
module edge_sync #(
    parameter bit RST_LEVEL = 1'b0,
    parameter bit FALLING   = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic async_i,
    output logic edge_o
);
    logic meta_q, sync_q, prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= RST_LEVEL;
            sync_q <= RST_LEVEL;
            prev_q <= RST_LEVEL;
        end else begin
            meta_q <= async_i;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    generate
        if (FALLING) begin : g_fall
            assign edge_o = prev_q & ~sync_q;
        end else begin : g_rise
            assign edge_o = sync_q & ~prev_q;
        end
    endgenerate

    AST_EDGE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        edge_o |=> !edge_o); // R10

endmodule

// File: rtl/ddc1_shifter.sv
module ddc1_shifter #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_i,
    input  logic              active_i,
    input  logic [DATA_W-1:0] hold_i,
    output logic              sda_q_o,
    output logic              ninth_o
);
    localparam int CNT_W = $clog2(DATA_W + 1);
    localparam logic [CNT_W-1:0] NULL_SLOT = CNT_W'(DATA_W);
    localparam logic [CNT_W-1:0] LAST_DATA = CNT_W'(DATA_W - 1);

    logic [CNT_W-1:0]  cnt_q;
    logic [DATA_W-1:0] shreg_q;
    logic              adv;

    assign adv     = tick_i & active_i;
    assign ninth_o = adv && (cnt_q == LAST_DATA);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= NULL_SLOT;
            shreg_q <= '0;
            sda_q_o <= 1'b1;
        end else if (adv) begin
            if (cnt_q == NULL_SLOT) begin
                cnt_q   <= '0;
                shreg_q <= hold_i;
                sda_q_o <= hold_i[DATA_W-1];
            end else if (cnt_q == LAST_DATA) begin
                cnt_q   <= NULL_SLOT;
                sda_q_o <= 1'b1;
            end else begin
                cnt_q   <= cnt_q + 1'b1;
                shreg_q <= shreg_q << 1;
                sda_q_o <= shreg_q[DATA_W-2];
            end
        end
    end

    AST_NULL_BIT: assert property (@(posedge clk) disable iff (rst)
        ninth_o |=> sda_q_o); // R2
    AST_IDLE_FREEZE: assert property (@(posedge clk) disable iff (rst)
        !adv |=> ($stable(cnt_q) && $stable(sda_q_o))); // R7
    AST_SLOT_RANGE: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= NULL_SLOT); // R2

endmodule

// File: rtl/ddc1_regfile.sv
module ddc1_regfile
    import edid_ddc1_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int PTR_W       = 8,
    parameter int SMALL_DEPTH = 128,
    parameter int LARGE_DEPTH = 256
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_wr_i,
    input  logic [1:0]        cpu_addr_i,
    input  logic [DATA_W-1:0] cpu_wdata_i,
    output logic [DATA_W-1:0] cpu_rdata_o,
    input  logic              ninth_i,
    input  logic              scl_fall_i,
    input  logic [DATA_W-1:0] buf_data_i,
    output ctrl_t             ctrl_o,
    output ddc_mode_e         mode_o,
    output logic [DATA_W-1:0] hold_o,
    output logic [PTR_W-1:0]  ptr_o,
    output logic              irq_o
);
    localparam logic [PTR_W:0] LIM_SMALL = (PTR_W + 1)'(SMALL_DEPTH);
    localparam logic [PTR_W:0] LIM_LARGE = (PTR_W + 1)'(LARGE_DEPTH);

    ctrl_t             ctrl_q;
    ddc_mode_e         mode_q;
    logic [DATA_W-1:0] hold_q;
    logic [PTR_W-1:0]  ptr_q;
    logic [PTR_W-1:0]  ptr_next;
    logic [PTR_W:0]    ptr_inc;
    logic              refill_flag_q, switch_flag_q;
    logic              wr_ctrl, wr_stat, wr_ptr, wr_hold;
    logic              hw_load, sw_event;
    stat_t             stat;

    assign wr_ctrl = cpu_wr_i && (cpu_addr_i == RA_CTRL);
    assign wr_stat = cpu_wr_i && (cpu_addr_i == RA_STAT);
    assign wr_ptr  = cpu_wr_i && (cpu_addr_i == RA_PTR);
    assign wr_hold = cpu_wr_i && (cpu_addr_i == RA_HOLD);

    assign hw_load  = ninth_i && !ctrl_q.sw_refill;
    assign sw_event = ninth_i &&  ctrl_q.sw_refill;

    always_comb begin
        ptr_inc  = {1'b0, ptr_q} + 1'b1;
        ptr_next = ptr_inc[PTR_W-1:0];
        if (ptr_inc >= (ctrl_q.size_large ? LIM_LARGE : LIM_SMALL)) begin
            ptr_next = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q        <= '0;
            mode_q        <= MODE_DDC1;
            hold_q        <= '0;
            ptr_q         <= '0;
            refill_flag_q <= 1'b0;
            switch_flag_q <= 1'b0;
        end else begin
            if (wr_ctrl) ctrl_q <= ctrl_t'(cpu_wdata_i[CTRL_W-1:0]);

            if (hw_load)     ptr_q <= ptr_next;
            else if (wr_ptr) ptr_q <= cpu_wdata_i[PTR_W-1:0];

            if (hw_load)      hold_q <= buf_data_i;
            else if (wr_hold) hold_q <= cpu_wdata_i;

            if (sw_event)                    refill_flag_q <= 1'b1;
            else if (wr_stat && cpu_wdata_i[0]) refill_flag_q <= 1'b0;

            if (scl_fall_i && mode_q == MODE_DDC1) switch_flag_q <= 1'b1;
            else if (wr_stat && cpu_wdata_i[1])    switch_flag_q <= 1'b0;

            if (scl_fall_i) mode_q <= MODE_DDC2;
        end
    end

    assign stat = '{mode: (mode_q == MODE_DDC2), switch_flag: switch_flag_q,
                    refill_flag: refill_flag_q};

    always_comb begin
        unique case (reg_sel_e'(cpu_addr_i))
            RA_CTRL: cpu_rdata_o = DATA_W'(ctrl_q);
            RA_STAT: cpu_rdata_o = DATA_W'(stat);
            RA_PTR:  cpu_rdata_o = DATA_W'(ptr_q);
            default: cpu_rdata_o = hold_q;
        endcase
    end

    assign ctrl_o = ctrl_q;
    assign mode_o = mode_q;
    assign hold_o = hold_q;
    assign ptr_o  = ptr_q;
    assign irq_o  = (refill_flag_q && ctrl_q.sw_refill) || switch_flag_q;

    AST_WRAP_SMALL: assert property (@(posedge clk) disable iff (rst)
        (hw_load && !ctrl_q.size_large && ptr_q == PTR_W'(SMALL_DEPTH - 1))
        |=> (ptr_q == '0)); // R4
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        (refill_flag_q && !(wr_stat && cpu_wdata_i[0])) |=> refill_flag_q); // R5
    AST_SW_PTR_KEPT: assert property (@(posedge clk) disable iff (rst)
        (sw_event && !wr_ptr) |=> $stable(ptr_q)); // R5
    AST_MODE_STICKY: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_DDC2) |=> (mode_q == MODE_DDC2)); // R9
    AST_SWITCH_RAISE: assert property (@(posedge clk) disable iff (rst)
        (scl_fall_i && mode_q == MODE_DDC1) |=> (switch_flag_q && irq_o)); // R8

endmodule

// File: rtl/edid_ddc1_tx.sv
module edid_ddc1_tx
    import edid_ddc1_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int PTR_W       = 8,
    parameter int SMALL_DEPTH = 128,
    parameter int LARGE_DEPTH = 256
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              vsync_clk_i,
    input  logic              ddc2_scl_i,
    input  logic              cpu_wr_i,
    input  logic [1:0]        cpu_addr_i,
    input  logic [DATA_W-1:0] cpu_wdata_i,
    output logic [DATA_W-1:0] cpu_rdata_o,
    output logic [PTR_W-1:0]  buf_addr_o,
    input  logic [DATA_W-1:0] buf_data_i,
    output logic              sda_o,
    output logic              irq_o
);
    logic              vs_rise, scl_fall, ninth, sda_q;
    logic [DATA_W-1:0] hold;
    ctrl_t             ctrl;
    ddc_mode_e         mode;

    edge_sync #(.RST_LEVEL(1'b0), .FALLING(1'b0)) u_vs_sync (
        .clk(clk), .rst(rst), .async_i(vsync_clk_i), .edge_o(vs_rise)
    );

    edge_sync #(.RST_LEVEL(1'b1), .FALLING(1'b1)) u_scl_sync (
        .clk(clk), .rst(rst), .async_i(ddc2_scl_i), .edge_o(scl_fall)
    );

    ddc1_shifter #(.DATA_W(DATA_W)) u_shift (
        .clk(clk), .rst(rst), .tick_i(vs_rise),
        .active_i(ctrl.enable && mode == MODE_DDC1),
        .hold_i(hold), .sda_q_o(sda_q), .ninth_o(ninth)
    );

    ddc1_regfile #(
        .DATA_W(DATA_W), .PTR_W(PTR_W),
        .SMALL_DEPTH(SMALL_DEPTH), .LARGE_DEPTH(LARGE_DEPTH)
    ) u_regs (
        .clk(clk), .rst(rst),
        .cpu_wr_i(cpu_wr_i), .cpu_addr_i(cpu_addr_i),
        .cpu_wdata_i(cpu_wdata_i), .cpu_rdata_o(cpu_rdata_o),
        .ninth_i(ninth), .scl_fall_i(scl_fall), .buf_data_i(buf_data_i),
        .ctrl_o(ctrl), .mode_o(mode), .hold_o(hold), .ptr_o(buf_addr_o),
        .irq_o(irq_o)
    );

    assign sda_o = sda_q | (mode == MODE_DDC2);

    AST_DDC2_PTR_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_DDC2 && !(cpu_wr_i && cpu_addr_i == RA_PTR))
        |=> $stable(buf_addr_o)); // R9
    AST_DISABLED_PTR: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.enable && !(cpu_wr_i && cpu_addr_i == RA_PTR))
        |=> $stable(buf_addr_o)); // R7

endmodule

// File: tb/edid_ddc1_tx_tb_top.sv
`timescale 1ns/1ps
module edid_ddc1_tx_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       vsync = 1'b0;
    logic       scl2 = 1'b1;
    logic       cpu_wr = 1'b0;
    logic [1:0] cpu_addr = 2'd0;
    logic [7:0] cpu_wdata = 8'd0;
    logic [7:0] cpu_rdata, buf_addr, buf_data;
    logic       sda, irq;
    int         n_checks = 0;
    int         n_fails  = 0;

    always #2.5 clk = ~clk;

    function automatic logic [7:0] mem(input logic [7:0] a);
        return a ^ 8'hA5;
    endfunction

    assign buf_data = mem(buf_addr);

    edid_ddc1_tx dut_i (
        .clk(clk), .rst(rst), .vsync_clk_i(vsync), .ddc2_scl_i(scl2),
        .cpu_wr_i(cpu_wr), .cpu_addr_i(cpu_addr), .cpu_wdata_i(cpu_wdata),
        .cpu_rdata_o(cpu_rdata), .buf_addr_o(buf_addr), .buf_data_i(buf_data),
        .sda_o(sda), .irq_o(irq)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_wr = 1'b1; cpu_addr = a; cpu_wdata = d;
        @(negedge clk);
        cpu_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        cpu_addr = a;
        #1 d = cpu_rdata;
    endtask

    task automatic vpulse(output logic b);
        @(negedge clk) vsync = 1'b1;
        repeat (4) @(negedge clk);
        b = sda;
        vsync = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic get_char(output logic [8:0] bits);
        logic b;
        bits = '0;
        for (int i = 0; i < 9; i++) begin
            vpulse(b);
            bits = {bits[7:0], b};
        end
    endtask

    task automatic t_reset();
        logic [7:0] d;
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), d);
            check(d == 8'h00, "R1 reset register", d, 0);
        end
        check(sda == 1'b1 && irq == 1'b0, "R1 reset outputs", {sda, irq}, 2'b10);
    endtask

    task automatic t_hw_stream();
        logic [8:0] c; logic [7:0] d;
        wr(2'd2, 8'd5); wr(2'd3, 8'h3C); wr(2'd0, 8'h01);
        get_char(c);
        check(c == {8'h3C, 1'b1}, "R2 first char", c, {8'h3C, 1'b1});
        rd(2'd2, d);
        check(d == 8'd6 && buf_addr == 8'd6, "R3 pointer advance", d, 6);
        rd(2'd3, d);
        check(d == mem(8'd5), "R3 hold refill", d, mem(8'd5));
        get_char(c);
        check(c == {mem(8'd5), 1'b1}, "R3 second char", c, {mem(8'd5), 1'b1});
    endtask

    task automatic t_latency();
        logic [8:0] c; logic b;
        wr(2'd3, 8'h11);
        @(negedge clk) vsync = 1'b1;
        repeat (2) @(negedge clk);
        check(sda == 1'b1, "R10 unchanged after two edges", sda, 1);
        @(negedge clk);
        check(sda == 1'b0, "R10 changed at third edge", sda, 0);
        vsync = 1'b0;
        repeat (4) @(negedge clk);
        c = '0;
        for (int i = 0; i < 8; i++) begin
            vpulse(b);
            c = {c[7:0], b};
        end
        check(c[7:0] == {7'h11, 1'b1}, "R2 rest of char", c[7:0], {7'h11, 1'b1});
    endtask

    task automatic t_wrap();
        logic [8:0] c; logic [7:0] d;
        wr(2'd2, 8'd127);
        get_char(c);
        rd(2'd2, d);
        check(d == 8'd0, "R4 small wrap", d, 0);
        rd(2'd3, d);
        check(d == mem(8'd127), "R4 small wrap hold", d, mem(8'd127));
        wr(2'd0, 8'h03); wr(2'd2, 8'd127);
        get_char(c);
        rd(2'd2, d);
        check(d == 8'd128, "R4 large no wrap at 128", d, 128);
        wr(2'd2, 8'd255);
        get_char(c);
        rd(2'd2, d);
        check(d == 8'd0, "R4 large wrap", d, 0);
        rd(2'd3, d);
        check(d == mem(8'd255), "R4 large wrap hold", d, mem(8'd255));
    endtask

    task automatic t_sw_refill();
        logic [8:0] c; logic [7:0] d, h0;
        wr(2'd0, 8'h05); wr(2'd2, 8'd10);
        rd(2'd3, h0);
        get_char(c);
        check(c == {h0, 1'b1}, "R5 char from hold", c, {h0, 1'b1});
        rd(2'd1, d);
        check(d[0] == 1'b1 && irq == 1'b1, "R5 flag and irq set", {d[0], irq}, 2'b11);
        rd(2'd2, d);
        check(d == 8'd10, "R5 pointer kept", d, 10);
        rd(2'd3, d);
        check(d == h0, "R5 hold kept", d, h0);
        repeat (20) @(negedge clk);
        rd(2'd1, d);
        check(d[0] == 1'b1, "R5 flag sticky", d[0], 1);
        wr(2'd3, 8'h96); wr(2'd1, 8'h01);
        rd(2'd1, d);
        check(d[0] == 1'b0 && irq == 1'b0, "R5 flag cleared", {d[0], irq}, 0);
        get_char(c);
        check(c == {8'h96, 1'b1}, "R5 CPU byte sent", c, {8'h96, 1'b1});
        wr(2'd1, 8'h01);
        get_char(c);
        check(c == {8'h96, 1'b1}, "R6 retransmit", c, {8'h96, 1'b1});
        wr(2'd1, 8'h01);
    endtask

    task automatic t_disable();
        logic [8:0] c; logic [7:0] p, d; logic b; logic all_high;
        wr(2'd0, 8'h00);
        rd(2'd2, p);
        all_high = 1'b1;
        for (int i = 0; i < 5; i++) begin
            vpulse(b);
            all_high &= b;
        end
        check(all_high, "R7 no bits while disabled", all_high, 1);
        rd(2'd2, d);
        check(d == p, "R7 pointer kept", d, p);
        wr(2'd3, 8'h5C); wr(2'd0, 8'h01);
        get_char(c);
        check(c == {8'h5C, 1'b1}, "R7 slot position kept", c, {8'h5C, 1'b1});
    endtask

    task automatic t_mode_switch();
        logic [7:0] d, p; logic b; logic all_high;
        rd(2'd1, d);
        check(d[2] == 1'b0, "R1 mode reads DDC1", d[2], 0);
        @(negedge clk) scl2 = 1'b0;
        repeat (4) @(negedge clk);
        rd(2'd1, d);
        check(d == 8'h06 && irq == 1'b1, "R8 switch", {d, irq}, {8'h06, 1'b1});
        rd(2'd2, p);
        all_high = 1'b1;
        for (int i = 0; i < 9; i++) begin
            vpulse(b);
            all_high &= b;
        end
        check(all_high, "R9 line released", all_high, 1);
        rd(2'd2, d);
        check(d == p, "R9 vsync ignored", d, p);
        wr(2'd1, 8'h02);
        rd(2'd1, d);
        check(d == 8'h04 && irq == 1'b0, "R8 switch flag cleared", {d, irq}, {8'h04, 1'b0});
        @(negedge clk) scl2 = 1'b1;
        repeat (4) @(negedge clk);
        scl2 = 1'b0;
        repeat (4) @(negedge clk);
        rd(2'd1, d);
        check(d == 8'h04, "R9 mode sticky, no new flag", d, 8'h04);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        t_reset();
        t_hw_stream();
        t_latency();
        t_wrap();
        t_sw_refill();
        t_disable();
        t_mode_switch();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule